// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Superpage Entries

This block is a small, fully associative cache of virtual-to-physical page translations. Each entry carries the ID of the process that owns it, so translations of several processes live side by side and nothing has to be discarded when the running process changes. A lookup presents a virtual page number, the current process ID and whether the access is a store. In the same cycle the block answers with a hit and the physical frame, a miss that tells the core to walk the page tables, or a permission fault.

An entry maps either one 4 KB page or an aligned superpage of `2**SP_BITS` pages. For a superpage, the low `SP_BITS` bits of the page number are left out of the tag compare and are copied from the virtual page number into the frame. Walk results are written through a fill port. Fills replace a matching entry rather than add a second copy. A free slot is used when one exists, and otherwise a round-robin victim. A purge port removes every entry of one process that covers a given page, and a flush input empties the whole cache in one cycle. These are the hooks that permission changes and cross-core shootdowns need.

Top module: `tagged_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup hits only when a valid entry has the same process ID and the same page. The frame is valid in the same cycle as the request. A fill is visible to lookups from the cycle after it is accepted.
- R3: An entry whose tag matches but whose process ID differs from `curPid` does not hit.
- R4: While `lookupValid` is high, exactly one of `hit`, `miss` and `permFault` is high, and `miss` means that no valid entry matches. While `lookupValid` is low, all three are low.
- R5: A superpage entry compares only page-number bits `[VPN_W-1:SP_BITS]`. Its frame is the entry's frame bits `[PFN_W-1:SP_BITS]` followed by the lookup's page-number bits `[SP_BITS-1:0]`.
- R6: A store that matches an entry with `fillWritable`=0 raises `permFault` and not `hit`. A load to that entry hits, and a store to a writable entry hits.
- R7: A fill whose process ID and page match a valid entry, compared at that entry's size, overwrites that entry, so no duplicate is ever created.
- R8: A fill that matches nothing goes to the lowest-numbered invalid entry. When every entry is valid, it goes to a round-robin pointer that starts at entry 0 after reset and advances by one, wrapping around, each time it is used.
- R9: A purge invalidates every valid entry of `purgePid` whose compare, at that entry's size, matches `purgeVpn`, including a superpage that covers the page. Other entries are left intact.
- R10: `flushAll` invalidates every entry at the next clock edge.
- R11: Priority is `flushAll`, then purge, then fill. A fill presented in the same cycle as a purge or flush is dropped.
- R12: When more than one entry matches a lookup, for example a 4 KB entry inside a superpage of the same process, the lowest-numbered entry supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | A translation is requested this cycle |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| curPid | input | PID_W | ID of the running process |
| isStore | input | 1 | The access is a write |
| hit | output | 1 | Translation found and access permitted |
| miss | output | 1 | No matching entry; a table walk is needed |
| permFault | output | 1 | Store to a read-only entry |
| frame | output | PFN_W | Physical frame number, meaningful with hit |
| fillValid | input | 1 | Write a walk result |
| fillPid | input | PID_W | Process ID of the new entry |
| fillVpn | input | VPN_W | Page number of the new entry |
| fillPfn | input | PFN_W | Frame number of the new entry |
| fillWritable | input | 1 | 1 = stores allowed |
| fillSuper | input | 1 | 1 = entry maps a superpage |
| purgeValid | input | 1 | Remove matching translations |
| purgePid | input | PID_W | Process ID of the purge |
| purgeVpn | input | VPN_W | Page number of the purge |
| flushAll | input | 1 | Invalidate every entry |

## Verification
A table of loads and stores is run against a fixed mix of entries. Two processes share one page number, which separates a process-ID match from a tag-only match. One page is read-only, which separates load and store permission. A superpage is probed at its first, last and first-outside page numbers, which exposes a wrong compare mask or a wrong pass-through of the low bits. Directed sequences then refill an existing page so that a duplicate would show up through lowest-index priority. They place a 4 KB page inside a superpage to check that priority and the purge of both. They fill past capacity, with a purged hole, to tell free-slot preference apart from round-robin order. They also combine fill with purge or flush in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic wrEn;     // write fill data into the selected slot
    logic purgeEn;  // clear slots matching the purge request
    logic clrAll;   // clear every valid bit
    logic advPtr;   // round-robin victim was consumed
  } tlb_strobe_t;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int N       = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int PID_W   = 8,
  parameter int SP_BITS = 10,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlb_strobe_t      strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [PID_W-1:0] fillPid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillWritable,
  input  logic             fillSuper,
  input  logic [PID_W-1:0] purgePid,
  input  logic [VPN_W-1:0] purgeVpn,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [PID_W-1:0] curPid,
  input  logic             isStore,
  output logic [N-1:0]     validVec,
  output logic [N-1:0]     fillMatchVec,
  output logic             hit,
  output logic             miss,
  output logic             permFault,
  output logic [PFN_W-1:0] frame
);
  localparam logic [VPN_W-1:0] LOW_MASK =
    {{(VPN_W-SP_BITS){1'b0}}, {SP_BITS{1'b1}}};

  logic [N-1:0]     validQ;
  logic [PID_W-1:0] pidQ [N];
  logic [VPN_W-1:0] vpnQ [N];
  logic [PFN_W-1:0] pfnQ [N];
  logic [N-1:0]     wrQ;
  logic [N-1:0]     supQ;

  logic [N-1:0]     lookMatch;
  logic [N-1:0]     purgeMatch;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [VPN_W-1:0] cmpMask;
    assign cmpMask = supQ[i] ? ~LOW_MASK : '1;
    assign lookMatch[i]    = validQ[i] && (pidQ[i] == curPid) &&
                             (((vpnQ[i] ^ lookupVpn) & cmpMask) == '0);
    assign fillMatchVec[i] = validQ[i] && (pidQ[i] == fillPid) &&
                             (((vpnQ[i] ^ fillVpn) & cmpMask) == '0);
    assign purgeMatch[i]   = validQ[i] && (pidQ[i] == purgePid) &&
                             (((vpnQ[i] ^ purgeVpn) & cmpMask) == '0);
  end

  assign validVec = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobe.clrAll) begin
      validQ <= '0;
    end else if (strobe.purgeEn) begin
      validQ <= validQ & ~purgeMatch;
    end else if (strobe.wrEn) begin
      validQ[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      pidQ[wrIdx] <= fillPid;
      vpnQ[wrIdx] <= fillVpn;
      pfnQ[wrIdx] <= fillPfn;
      wrQ[wrIdx]  <= fillWritable;
      supQ[wrIdx] <= fillSuper;
    end
  end

  // Lowest matching index wins.
  logic [IDX_W-1:0] selIdx;
  logic             anyMatch;
  always_comb begin
    selIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lookMatch[i]) selIdx = IDX_W'(i);
    end
  end
  assign anyMatch = |lookMatch;

  logic denied;
  assign denied    = isStore && !wrQ[selIdx];
  assign hit       = lookupValid && anyMatch && !denied;
  assign permFault = lookupValid && anyMatch && denied;
  assign miss      = lookupValid && !anyMatch;
  assign frame     = supQ[selIdx] ?
                     {pfnQ[selIdx][PFN_W-1:SP_BITS], lookupVpn[SP_BITS-1:0]} :
                     pfnQ[selIdx];
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int N      = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  input  logic             purgeValid,
  input  logic             flushAll,
  input  logic [N-1:0]     validVec,
  input  logic [N-1:0]     fillMatchVec,
  output tlb_strobe_t      strobe,
  output logic [IDX_W-1:0] wrIdx
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx;
  logic [IDX_W-1:0] freeIdx;
  logic             hasMatch;
  logic             hasFree;

  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (fillMatchVec[i]) matchIdx = IDX_W'(i);
      if (!validVec[i])    freeIdx  = IDX_W'(i);
    end
  end

  assign hasMatch = |fillMatchVec;
  assign hasFree  = !(&validVec);

  always_comb begin
    strobe.clrAll  = flushAll;
    strobe.purgeEn = purgeValid && !flushAll;
    strobe.wrEn    = fillValid && !purgeValid && !flushAll;
    strobe.advPtr  = strobe.wrEn && !hasMatch && !hasFree;
    if (hasMatch)     wrIdx = matchIdx;
    else if (hasFree) wrIdx = freeIdx;
    else              wrIdx = rrPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.advPtr) begin
      rrPtr <= (rrPtr == IDX_W'(N - 1)) ? '0 : rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tlb_pkg::*;
#(
  parameter int N       = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int PID_W   = 8,
  parameter int SP_BITS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [PID_W-1:0] curPid,
  input  logic             isStore,
  output logic             hit,
  output logic             miss,
  output logic             permFault,
  output logic [PFN_W-1:0] frame,
  input  logic             fillValid,
  input  logic [PID_W-1:0] fillPid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillWritable,
  input  logic             fillSuper,
  input  logic             purgeValid,
  input  logic [PID_W-1:0] purgePid,
  input  logic [VPN_W-1:0] purgeVpn,
  input  logic             flushAll
);
  localparam int IDX_W = $clog2(N);

  tlb_strobe_t      strobe;
  logic [IDX_W-1:0] wrIdx;
  logic [N-1:0]     validVec;
  logic [N-1:0]     fillMatchVec;

  tlb_control #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .purgeValid(purgeValid), .flushAll(flushAll),
    .validVec(validVec), .fillMatchVec(fillMatchVec),
    .strobe(strobe), .wrIdx(wrIdx)
  );

  tlb_datapath #(
    .N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W), .SP_BITS(SP_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .fillPid(fillPid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillWritable(fillWritable), .fillSuper(fillSuper),
    .purgePid(purgePid), .purgeVpn(purgeVpn),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .curPid(curPid),
    .isStore(isStore),
    .validVec(validVec), .fillMatchVec(fillMatchVec),
    .hit(hit), .miss(miss), .permFault(permFault), .frame(frame)
  );
endmodule

// File: rtl/tagged_tlb_checker.sv
module tagged_tlb_checker #(
  parameter int VPN_W = 20,
  parameter int PID_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [VPN_W-1:0] lookupVpn,
  input logic [PID_W-1:0] curPid,
  input logic             isStore,
  input logic             hit,
  input logic             miss,
  input logic             permFault,
  input logic             fillValid,
  input logic [PID_W-1:0] fillPid,
  input logic [VPN_W-1:0] fillVpn,
  input logic             purgeValid,
  input logic [PID_W-1:0] purgePid,
  input logic [VPN_W-1:0] purgeVpn,
  input logic             flushAll
);
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> ($countones({hit, miss, permFault}) == 1));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(hit || miss || permFault));

  p_fault_store_r6: assert property (@(posedge clk) disable iff (!rstN)
    permFault |-> isStore);

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> !(hit || permFault));

  p_fill_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !purgeValid && !flushAll) |=>
      (!(lookupValid && !isStore && curPid == $past(fillPid) &&
         lookupVpn == $past(fillVpn)) || hit));

  p_purge_removes_r9: assert property (@(posedge clk) disable iff (!rstN)
    purgeValid |=>
      !(lookupValid && (hit || permFault) && curPid == $past(purgePid) &&
        lookupVpn == $past(purgeVpn)));
endmodule

bind tagged_tlb tagged_tlb_checker #(.VPN_W(VPN_W), .PID_W(PID_W)) u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
  .curPid(curPid), .isStore(isStore), .hit(hit), .miss(miss),
  .permFault(permFault), .fillValid(fillValid), .fillPid(fillPid),
  .fillVpn(fillVpn), .purgeValid(purgeValid), .purgePid(purgePid),
  .purgeVpn(purgeVpn), .flushAll(flushAll)
);

// File: tb/tagged_tlb_bench.sv
module tagged_tlb_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [19:0] lookupVpn = '0;
  logic [7:0]  curPid = '0;
  logic        isStore = 1'b0;
  logic        hit, miss, permFault;
  logic [19:0] frame;
  logic        fillValid = 1'b0;
  logic [7:0]  fillPid = '0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillPfn = '0;
  logic        fillWritable = 1'b0;
  logic        fillSuper = 1'b0;
  logic        purgeValid = 1'b0;
  logic [7:0]  purgePid = '0;
  logic [19:0] purgeVpn = '0;
  logic        flushAll = 1'b0;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tagged_tlb u_tagged_tlb (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .curPid(curPid), .isStore(isStore), .hit(hit), .miss(miss),
    .permFault(permFault), .frame(frame), .fillValid(fillValid),
    .fillPid(fillPid), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillWritable(fillWritable), .fillSuper(fillSuper),
    .purgeValid(purgeValid), .purgePid(purgePid), .purgeVpn(purgeVpn),
    .flushAll(flushAll)
  );

  // kind: 0 miss, 1 hit, 2 permission fault
  // {pid[50:43], vpn[42:23], store[22], kind[21:20], frame[19:0]}
  localparam int NVEC = 12;
  localparam logic [50:0] VEC [NVEC] = '{
    {8'd1, 20'h00010, 1'b0, 2'd1, 20'h00A00},  // R2 load hit
    {8'd1, 20'h00010, 1'b1, 2'd1, 20'h00A00},  // R6 store to writable
    {8'd2, 20'h00010, 1'b0, 2'd1, 20'h00B00},  // R3 other process, own entry
    {8'd2, 20'h00010, 1'b1, 2'd2, 20'h00000},  // R6 store to read-only
    {8'd3, 20'h00010, 1'b0, 2'd0, 20'h00000},  // R3 unknown process
    {8'd1, 20'h40123, 1'b0, 2'd1, 20'h80123},  // R5 inside superpage
    {8'd1, 20'h403FF, 1'b1, 2'd1, 20'h803FF},  // R5 last page of superpage
    {8'd1, 20'h40400, 1'b0, 2'd0, 20'h00000},  // R5 first page outside
    {8'd2, 20'h40123, 1'b0, 2'd0, 20'h00000},  // R3 superpage other pid
    {8'd1, 20'h00020, 1'b1, 2'd2, 20'h00000},  // R6 read-only store
    {8'd1, 20'h00020, 1'b0, 2'd1, 20'h00C00},  // R6 read-only load
    {8'd1, 20'h00011, 1'b0, 2'd0, 20'h00000}   // R4 neighbour page misses
  };

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic chk(input string req, input logic [7:0] pid,
                     input logic [19:0] vpn, input logic st,
                     input int expKind, input logic [19:0] expFrame);
    int actKind;
    @(negedge clk);
    lookupValid = 1'b1; curPid = pid; lookupVpn = vpn; isStore = st;
    #1;
    actKind = hit ? 1 : (permFault ? 2 : (miss ? 0 : 3));
    total++;
    if (actKind != expKind || (expKind == 1 && frame !== expFrame)) begin
      fails++;
      $display("FAIL %s: pid=%0d vpn=%h kind=%0d frame=%h expected kind=%0d frame=%h",
               req, pid, vpn, actKind, frame, expKind, expFrame);
    end
  endtask

  task automatic doFill(input logic [7:0] pid, input logic [19:0] vpn,
                        input logic [19:0] pfn, input logic wr, input logic sp);
    @(negedge clk);
    fillValid = 1'b1; fillPid = pid; fillVpn = vpn; fillPfn = pfn;
    fillWritable = wr; fillSuper = sp;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doPurge(input logic [7:0] pid, input logic [19:0] vpn);
    @(negedge clk);
    purgeValid = 1'b1; purgePid = pid; purgeVpn = vpn;
    @(negedge clk);
    purgeValid = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flushAll = 1'b1;
    @(negedge clk);
    flushAll = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: empty after reset
    chk("R1", 8'd1, 20'h00010, 1'b0, 0, 20'h0);

    // Setup entries for the table
    doFill(8'd1, 20'h00010, 20'h00A00, 1'b1, 1'b0);
    doFill(8'd2, 20'h00010, 20'h00B00, 1'b0, 1'b0);
    doFill(8'd1, 20'h40000, 20'h80000, 1'b1, 1'b1);
    doFill(8'd1, 20'h00020, 20'h00C00, 1'b0, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      chk($sformatf("vector %0d (R2-R6)", k), VEC[k][50:43], VEC[k][42:23],
          VEC[k][22], int'(VEC[k][21:20]), VEC[k][19:0]);
    end

    // R7: refill of an existing page replaces it, no duplicate
    doFill(8'd1, 20'h00010, 20'h0AAAA, 1'b1, 1'b0);
    chk("R7 refill", 8'd1, 20'h00010, 1'b0, 1, 20'h0AAAA);
    doPurge(8'd1, 20'h00010);
    chk("R7 single copy", 8'd1, 20'h00010, 1'b0, 0, 20'h0);

    // R10: flush empties everything
    doFlush();
    chk("R10 page", 8'd2, 20'h00010, 1'b0, 0, 20'h0);
    chk("R10 superpage", 8'd1, 20'h40123, 1'b0, 0, 20'h0);

    // R11: fill dropped when flush or purge share its cycle
    @(negedge clk);
    fillValid = 1'b1; fillPid = 8'd4; fillVpn = 20'h00050;
    fillPfn = 20'h00D00; fillWritable = 1'b1; fillSuper = 1'b0;
    flushAll = 1'b1;
    @(negedge clk);
    fillValid = 1'b0; flushAll = 1'b0;
    chk("R11 flush wins", 8'd4, 20'h00050, 1'b0, 0, 20'h0);
    @(negedge clk);
    fillValid = 1'b1; purgeValid = 1'b1; purgePid = 8'd9; purgeVpn = 20'h0;
    @(negedge clk);
    fillValid = 1'b0; purgeValid = 1'b0;
    chk("R11 purge wins", 8'd4, 20'h00050, 1'b0, 0, 20'h0);

    // R12: 4 KB page inside a superpage, lower index wins
    doFill(8'd5, 20'h00805, 20'h11111, 1'b1, 1'b0);
    doFill(8'd5, 20'h00800, 20'h20000, 1'b1, 1'b1);
    doFill(8'd5, 20'h01000, 20'h33333, 1'b1, 1'b0);
    chk("R12 lowest index", 8'd5, 20'h00805, 1'b0, 1, 20'h11111);
    chk("R12 superpage rest", 8'd5, 20'h00806, 1'b0, 1, 20'h20006);
    // R9: purge removes both covering entries, leaves others
    doPurge(8'd5, 20'h00805);
    chk("R9 page gone", 8'd5, 20'h00805, 1'b0, 0, 20'h0);
    chk("R9 superpage gone", 8'd5, 20'h00806, 1'b0, 0, 20'h0);
    chk("R9 other kept", 8'd5, 20'h01000, 1'b0, 1, 20'h33333);

    // R8: free slots first, then round robin from entry 0
    doFlush();
    for (int k = 0; k < 8; k++) doFill(8'd7, 20'(k), 20'h00100 + 20'(k), 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) chk("R8 filled", 8'd7, 20'(k), 1'b0, 1, 20'h00100 + 20'(k));
    doFill(8'd7, 20'd8, 20'h00108, 1'b1, 1'b0);
    chk("R8 victim 0", 8'd7, 20'd0, 1'b0, 0, 20'h0);
    chk("R8 new entry", 8'd7, 20'd8, 1'b0, 1, 20'h00108);
    chk("R8 entry 1 kept", 8'd7, 20'd1, 1'b0, 1, 20'h00101);
    doFill(8'd7, 20'd9, 20'h00109, 1'b1, 1'b0);
    chk("R8 victim 1", 8'd7, 20'd1, 1'b0, 0, 20'h0);
    doPurge(8'd7, 20'd5);
    doFill(8'd7, 20'd10, 20'h0010A, 1'b1, 1'b0);
    chk("R8 hole used", 8'd7, 20'd10, 1'b0, 1, 20'h0010A);
    chk("R8 pointer held", 8'd7, 20'd2, 1'b0, 1, 20'h00102);
    doFill(8'd7, 20'd11, 20'h0010B, 1'b1, 1'b0);
    chk("R8 victim 2", 8'd7, 20'd2, 1'b0, 0, 20'h0);
    chk("R8 entry 3 kept", 8'd7, 20'd3, 1'b0, 1, 20'h00103);

    @(negedge clk);
    lookupValid = 1'b0;
    summary();
    $finish;
  end
endmodule